// File: doc/BRIEF.md
# Motor Voltage Regulation Loop

This block holds the average voltage across a brushed motor at a requested level by adjusting the duty cycle of the bridge drive. It works even when the supply voltage drifts, for example as a battery discharges. A sampled word carries the averaged differential voltage across the motor, qualified by a valid strobe. The block divides that word by four and compares it with a setpoint. On each update tick it moves an internal duty register one step toward balance.

A free-running PWM counter is compared against the duty register. The result is an on/off phase signal for the bridge sequencer that follows this block. Two control inputs override the loop:

- A restart pulse drops the duty to zero, so that the drive ramps up again gradually.
- A current-limit request forces the duty downward whatever the voltage comparison says.

When the setpoint is out of reach, the duty stops at full scale. The phase output then stays on continuously, so the bridge behaves as a plain driver.

Top module: `motor_vreg`

## Requirements
- R1: While reset is asserted and on the first cycles after its release, `duty` is 0 and `pwm_on` is 0.
- R2: A measurement is captured on a clock edge where `meas_valid` is high. Its two least significant bits are dropped, which gives the scaled value. On an update tick where the scaled value plus one is below `setpoint`, `duty` rises by one.
- R3: On an update tick where the scaled value exceeds `setpoint` plus one, `duty` falls by one.
- R4: On an update tick where the scaled value is within one LSB of `setpoint`, `duty` is unchanged.
- R5: `duty` changes by at most one per tick. It saturates at 255 and at 0 and never wraps.
- R6: On an update tick where `ilim_req` is high, `duty` falls by one (stopping at 0), regardless of the comparison.
- R7: A clock edge with `restart` high sets `duty` to 0. It also restarts both the tick interval and the PWM period. `restart` takes priority over every other input.
- R8: Update ticks occur every TICK_DIV clocks, where TICK_DIV = floor(CLK_KHZ*RAMP_US/(1000*255)), and at least 1. The first tick after a restart lands on the TICK_DIV-th edge. `duty` does not change between ticks.
- R9: The PWM counter advances once every PRESCALE clocks over 256 counts. `pwm_on` is high while the counter is below `duty`, and constantly high when `duty` is 255. With `duty` at 0 it is always low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| meas_valid | input | 1 | Strobe qualifying `meas_word` |
| meas_word | input | MEAS_W | Averaged motor voltage sample |
| setpoint | input | MEAS_W-2 | Requested voltage, in units of one quarter of the measurement scale |
| restart | input | 1 | Single-cycle pulse that restarts the ramp from zero |
| ilim_req | input | 1 | Current-limit reduce request |
| duty | output | DUTY_W | Present duty value |
| pwm_on | output | 1 | Bridge drive phase: 1 = drive, 0 = recirculate |

## Verification
The assertions rely on every input being synchronous to `clk` and free of unknown values once reset is released. In particular, they treat `restart` as the only event allowed to move `duty` by more than one step. The bench changes all inputs on the falling edge and holds `meas_valid` and `restart` for exactly one cycle. It issues a restart before every ramp measurement, so that tick alignment is known. A behavioural reference model runs on the same edges, and its duty and phase are compared with the outputs on every cycle.

// File: rtl/motor_vreg.sv
module motor_vreg #(
  parameter int MEAS_W   = 10,
  parameter int DUTY_W   = 8,
  parameter int CLK_KHZ  = 50000,
  parameter int RAMP_US  = 12000,
  parameter int PRESCALE = 4,
  parameter int DEADBAND = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              meas_valid,
  input  logic [MEAS_W-1:0] meas_word,
  input  logic [MEAS_W-3:0] setpoint,
  input  logic              restart,
  input  logic              ilim_req,
  output logic [DUTY_W-1:0] duty,
  output logic              pwm_on
);

  localparam int    SW       = MEAS_W - 2;
  localparam int    DUTY_MAX = (1 << DUTY_W) - 1;
  localparam longint RAMP_CLK = longint'(CLK_KHZ) * longint'(RAMP_US) / 1000;
  localparam int    TICK_RAW = int'(RAMP_CLK / DUTY_MAX);
  localparam int    TICK_DIV = (TICK_RAW < 1) ? 1 : TICK_RAW;
  localparam int    TW       = $clog2(TICK_DIV + 1);
  localparam int    PW       = $clog2(PRESCALE + 1);

  logic [SW-1:0]     meas_q;
  logic [TW-1:0]     tick_cnt;
  logic [PW-1:0]     pre_cnt;
  logic [DUTY_W-1:0] pwm_cnt;
  logic [SW+1:0]     meas_ext, meas_hi, set_ext, set_hi;
  logic              tick, pre_wrap, go_up, go_down, at_max, at_min;

  assign meas_ext = {2'b00, meas_q};
  assign set_ext  = {2'b00, setpoint};
  assign meas_hi  = meas_ext + (SW+2)'(DEADBAND);
  assign set_hi   = set_ext + (SW+2)'(DEADBAND);
  assign go_up    = meas_hi < set_ext;
  assign go_down  = meas_ext > set_hi;

  assign tick     = tick_cnt == TW'(TICK_DIV - 1);
  assign pre_wrap = pre_cnt == PW'(PRESCALE - 1);
  assign at_max   = duty == DUTY_W'(DUTY_MAX);
  assign at_min   = duty == '0;
  assign pwm_on   = at_max | (pwm_cnt < duty);

  always_ff @(posedge clk) begin
    if (!rst_n)          meas_q <= '0;
    else if (meas_valid) meas_q <= meas_word[MEAS_W-1:2];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart) tick_cnt <= '0;
    else if (tick)         tick_cnt <= '0;
    else                   tick_cnt <= tick_cnt + TW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      pre_cnt <= '0;
      pwm_cnt <= '0;
    end else if (pre_wrap) begin
      pre_cnt <= '0;
      pwm_cnt <= pwm_cnt + DUTY_W'(1);
    end else begin
      pre_cnt <= pre_cnt + PW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart) duty <= '0;
    else if (tick) begin
      if (ilim_req) begin
        if (!at_min) duty <= duty - DUTY_W'(1);
      end else if (go_up) begin
        if (!at_max) duty <= duty + DUTY_W'(1);
      end else if (go_down) begin
        if (!at_min) duty <= duty - DUTY_W'(1);
      end
    end
  end

  p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(restart) |-> (duty == $past(duty)) || (duty == $past(duty) + DUTY_W'(1))
                        || (duty == $past(duty) - DUTY_W'(1)));
  p_nowrap_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(duty) == DUTY_W'(DUTY_MAX)) && !$past(restart) |-> duty != '0);
  p_nowrap_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(duty) == '0) && !$past(restart) |-> duty != DUTY_W'(DUTY_MAX));
  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> duty == '0);
  p_ilim_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tick && ilim_req && !restart && (duty != '0) |=> duty == $past(duty) - DUTY_W'(1));
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !restart |=> $stable(duty));
  p_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    at_max |-> pwm_on);
  p_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    at_min |-> !pwm_on);

endmodule

// File: tb/motor_vreg_test.sv
`timescale 1ns/1ps
module motor_vreg_test;
  localparam int CK = 1000, RU = 1020, PS = 2;
  localparam int TD = 4;

  logic       clk = 0, rst_n = 0, meas_valid = 0, restart = 0, ilim_req = 0;
  logic [9:0] meas_word = '0;
  logic [7:0] setpoint = '0;
  logic [7:0] duty;
  logic       pwm_on;
  int checks = 0, errors = 0;
  int m_duty = 0, m_meas = 0, m_tick = 0, m_pre = 0, m_pwm = 0;
  bit done = 0;

  motor_vreg #(.MEAS_W(10), .DUTY_W(8), .CLK_KHZ(CK), .RAMP_US(RU), .PRESCALE(PS), .DEADBAND(1)) uut (
    .clk(clk), .rst_n(rst_n), .meas_valid(meas_valid), .meas_word(meas_word),
    .setpoint(setpoint), .restart(restart), .ilim_req(ilim_req), .duty(duty), .pwm_on(pwm_on));

  always #2.5 clk = ~clk;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    int nm;
    if (!rst_n) begin
      m_duty = 0; m_meas = 0; m_tick = 0; m_pre = 0; m_pwm = 0;
    end else begin
      nm = meas_valid ? int'(meas_word) / 4 : m_meas;
      if (restart) begin
        m_duty = 0; m_tick = 0; m_pre = 0; m_pwm = 0;
      end else begin
        if (m_tick == TD - 1) begin
          m_tick = 0;
          if (ilim_req) begin
            if (m_duty > 0) m_duty--;
          end else if (m_meas + 1 < int'(setpoint)) begin
            if (m_duty < 255) m_duty++;
          end else if (m_meas > int'(setpoint) + 1) begin
            if (m_duty > 0) m_duty--;
          end
        end else m_tick++;
        if (m_pre == PS - 1) begin
          m_pre = 0; m_pwm = (m_pwm + 1) % 256;
        end else m_pre++;
      end
      m_meas = nm;
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    check("R2 duty vs reference", int'(duty), m_duty);
    check("R9 phase vs reference", int'(pwm_on), int'((m_duty == 255) || (m_pwm < m_duty)));
  end

  task automatic set_meas(int v);
    @(negedge clk); meas_word = 10'(v); meas_valid = 1;
    @(negedge clk); meas_valid = 0;
  endtask

  task automatic pulse_restart();
    @(negedge clk); restart = 1;
    @(negedge clk); restart = 0;
  endtask

  task automatic wait_ticks(int n);
    repeat (n * TD) @(negedge clk);
  endtask

  task automatic count_on(output int highs);
    highs = 0;
    for (int i = 0; i < 256 * PS; i++) begin
      @(negedge clk);
      if (pwm_on) highs++;
    end
  endtask

  initial begin
    int d0, highs;
    repeat (3) @(negedge clk);
    check("R1 duty in reset", int'(duty), 0);
    check("R1 phase in reset", int'(pwm_on), 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 duty after reset", int'(duty), 0);
    check("R1 phase after reset", int'(pwm_on), 0);

    setpoint = 255;
    set_meas(0);
    pulse_restart();
    repeat (TD - 1) @(negedge clk);
    check("R8 no step before first tick", int'(duty), 0);
    @(negedge clk);
    check("R8 step on first tick", int'(duty), 1);
    wait_ticks(270);
    check("R5 saturates at top", int'(duty), 255);
    count_on(highs);
    check("R9 full duty stays on", highs, 256 * PS);
    check("R5 no wrap past top", int'(duty), 255);

    setpoint = 100;
    set_meas(4 * 150);
    d0 = int'(duty);
    wait_ticks(5);
    check("R3 falls when above", int'(duty), d0 - 5);

    set_meas(4 * 101);
    d0 = int'(duty);
    wait_ticks(10);
    check("R4 hold at plus one", int'(duty), d0);
    count_on(highs);
    check("R9 on count equals duty", highs, d0 * PS);
    set_meas(4 * 99 + 3);
    wait_ticks(8);
    check("R4 hold at minus one after truncation", int'(duty), d0);

    set_meas(4 * 102);
    d0 = int'(duty);
    wait_ticks(5);
    check("R3 falls at plus two", int'(duty), d0 - 5);

    set_meas(4 * 97 + 3);
    d0 = int'(duty);
    wait_ticks(5);
    check("R2 rises at minus three", int'(duty), d0 + 5);

    @(negedge clk); ilim_req = 1;
    d0 = int'(duty);
    wait_ticks(5);
    check("R6 current limit overrides rise", int'(duty), d0 - 5);
    @(negedge clk); ilim_req = 0;

    setpoint = 0;
    set_meas(1023);
    wait_ticks(300);
    check("R5 saturates at bottom", int'(duty), 0);
    count_on(highs);
    check("R9 zero duty stays off", highs, 0);

    setpoint = 255;
    set_meas(0);
    wait_ticks(20);
    check("R7 duty nonzero before restart", int'(duty > 0), 1);
    @(negedge clk); restart = 1; ilim_req = 1;
    @(negedge clk); restart = 0; ilim_req = 0;
    check("R7 restart clears duty", int'(duty), 0);
    check("R7 restart clears phase", int'(pwm_on), 0);
    wait_ticks(3);
    check("R8 ramp pace after restart", int'(duty), 3);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    done = 1;
    checks++; errors++;
    $display("FAIL R8 watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule